// File: doc/BRIEF.md
# Block RAM Initialisation Loader

This block turns a decoded configuration stream into write cycles for a grid of block RAMs (4 columns by 8 rows by default). The stream arrives as commands: a one-cycle command strobe carrying an opcode, followed by payload bytes, one per data beat. A command ends when the next command strobe arrives. There is no end-of-payload marker and no framing check.

Five opcodes are handled. Two of them pick the target blocks. One takes a single coordinate. The other takes a column mask that enables every row of each flagged column. A third opcode loads a 16-bit start address. A bulk data opcode streams RAM contents to successive addresses. A short configuration opcode writes a few per-block configuration bytes. Every accepted payload byte leaves through one registered write port. That port carries a block mask, an address, the data byte and a flag that separates configuration writes from content writes. Two sticky flags report a rejected command and a truncated bulk payload.

Top module: `blkinit_loader`

## Requirements
- R1: After reset, wr_en, err and ovf are 0. A payload byte that arrives before any command has been issued causes no write.
- R2: Opcode 0 (select) takes column = byte0[1:0] and row = byte1[2:0]; other bits are ignored. After its second byte, the selection is exactly mask bit row*4+col.
- R3: Opcode 1 (pattern) takes one byte. Bit c (c = 0..3) selects all 8 rows of column c, which are mask bits r*4+c. Bits 7:4 are ignored, and a low nibble of zero clears the selection.
- R4: Opcode 2 (address) takes the low byte first, then the high byte. The new start address applies only after the second byte.
- R5: Opcode 3 (bulk) produces one write per payload byte, one clock after that byte. Each write has wr_cfg=0 and wr_mask equal to the selection. The first address is the start address, and the address rises by 1 for each byte.
- R6: The bulk address wraps from 0xFFFF to 0x0000. A later bulk command issued without a new address continues from where the previous one stopped.
- R7: A bulk command issued while no block is selected or no address has been loaded produces no writes, and err becomes 1 and stays 1 until reset.
- R8: Bulk bytes after the 5120th are not written, and ovf becomes 1 and stays 1 until reset.
- R9: Opcode 4 (config) writes payload byte k with wr_cfg=1 and wr_addr=k for k < 27. Later bytes are dropped without a flag. With no selection, it writes nothing and sets err.
- R10: A payload byte in the same cycle as a command strobe is discarded, and the new command's first byte is the next beat. Payloads of opcodes 5 to 7 are ignored.
- R11: A select or address command cut short after its first byte leaves the previous selection or address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Opcode presented with cmd_valid |
| dat_valid | input | 1 | Payload byte strobe |
| dat_byte | input | 8 | Payload byte |
| wr_en | output | 1 | Write strobe |
| wr_cfg | output | 1 | 1: configuration write, 0: content write |
| wr_mask | output | 32 | Target blocks, bit row*4+col |
| wr_addr | output | 16 | Write address |
| wr_data | output | 8 | Write data |
| err | output | 1 | Sticky: a data command was rejected |
| ovf | output | 1 | Sticky: a bulk payload was truncated |

## Verification
Two events can arrive in the same cycle: the start of a new command and a payload beat of the running bulk transfer. The bench drives both strobes together in the middle of a bulk stream. It then checks that no write appears on the following clock and that the next beat is written at the continued address. The overflow boundary also merges two events: the beat that would be written at index 5120 must raise ovf in the same cycle that wr_en stays low. The bench checks both outputs on that exact clock.

// File: rtl/blkinit_pkg.sv
`timescale 1ns/1ps
package blkinit_pkg;

    typedef enum logic [2:0] {
        OP_SELECT  = 3'd0,
        OP_PATTERN = 3'd1,
        OP_ADDR    = 3'd2,
        OP_BULK    = 3'd3,
        OP_CFG     = 3'd4
    } op_e;

    // Write kinds leaving the loader
    typedef enum logic {
        WK_RAM = 1'b0,
        WK_CFG = 1'b1
    } wr_kind_e;

    function automatic logic op_needs_addr(op_e op);
        return op == OP_BULK;
    endfunction

    function automatic logic op_writes(op_e op);
        return (op == OP_BULK) || (op == OP_CFG);
    endfunction

endpackage

// File: rtl/blkinit_cmd_track.sv
`timescale 1ns/1ps
module blkinit_cmd_track
    import blkinit_pkg::*;
#(
    parameter int BULK_MAX = 5120,
    parameter int CNT_W    = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic             dat_valid,
    output op_e              cur_op,
    output logic [CNT_W-1:0] idx,
    output logic             beat_go
);

    localparam logic [CNT_W-1:0] IDX_SAT = CNT_W'(BULK_MAX);

    logic active;

    assign beat_go = dat_valid && !cmd_valid && active;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cur_op <= OP_SELECT;
            idx    <= '0;
        end else if (cmd_valid) begin
            active <= 1'b1;
            cur_op <= op_e'(cmd_op);
            idx    <= '0;
        end else if (beat_go && idx != IDX_SAT) begin
            idx <= idx + 1'b1;
        end
    end

    // R10
    idx_restart_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> idx == '0);

endmodule

// File: rtl/blkinit_sel.sv
`timescale 1ns/1ps
module blkinit_sel
    import blkinit_pkg::*;
#(
    parameter int N_COL = 4,
    parameter int N_ROW = 8,
    parameter int CNT_W = 13,
    localparam int COL_W = $clog2(N_COL),
    localparam int ROW_W = $clog2(N_ROW),
    localparam int N_BLK = N_COL * N_ROW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             beat_go,
    input  op_e              op,
    input  logic [CNT_W-1:0] idx,
    input  logic [COL_W-1:0] col_bits,
    input  logic [ROW_W-1:0] row_bits,
    input  logic [N_COL-1:0] pat_bits,
    output logic [N_BLK-1:0] mask,
    output logic             sel_any
);

    logic [COL_W-1:0] col_q;
    logic [N_BLK-1:0] pat_mask;
    logic [N_BLK-1:0] pt_mask;

    for (genvar c = 0; c < N_COL; c++) begin : g_col
        for (genvar r = 0; r < N_ROW; r++) begin : g_row
            assign pat_mask[r*N_COL + c] = pat_bits[c];
        end
    end

    always_comb begin
        pt_mask = '0;
        pt_mask[{row_bits, col_q}] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q <= '0;
            mask  <= '0;
        end else if (beat_go) begin
            if (op == OP_SELECT) begin
                if (idx == '0)
                    col_q <= col_bits;
                else if (idx == CNT_W'(1))
                    mask <= pt_mask;
            end else if (op == OP_PATTERN && idx == '0) begin
                mask <= pat_mask;
            end
        end
    end

    assign sel_any = |mask;

    // R2
    select_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        (beat_go && op == OP_SELECT && idx == CNT_W'(1)) |=> $countones(mask) == 1);

endmodule

// File: rtl/blkinit_addr.sv
`timescale 1ns/1ps
module blkinit_addr
    import blkinit_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 13,
    localparam int NB    = (ADDR_W + 7) / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              beat_go,
    input  op_e               op,
    input  logic [CNT_W-1:0]  idx,
    input  logic [7:0]        byte_in,
    input  logic              bump,
    output logic [ADDR_W-1:0] addr,
    output logic              addr_ok
);

    localparam logic [CNT_W-1:0] IDX_LAST = CNT_W'(NB - 1);

    logic [(NB-1)*8-1:0] stage;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage   <= '0;
            addr    <= '0;
            addr_ok <= 1'b0;
        end else if (beat_go && op == OP_ADDR) begin
            for (int i = 0; i < NB - 1; i++) begin
                if (idx == CNT_W'(i))
                    stage[i*8 +: 8] <= byte_in;
            end
            if (idx == IDX_LAST) begin
                addr    <= ADDR_W'({byte_in, stage});
                addr_ok <= 1'b1;
            end
        end else if (bump) begin
            addr <= addr + 1'b1;
        end
    end

    // R4
    addr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        addr_ok |=> addr_ok);

endmodule

// File: rtl/blkinit_loader.sv
`timescale 1ns/1ps
module blkinit_loader
    import blkinit_pkg::*;
#(
    parameter int N_COL    = 4,
    parameter int N_ROW    = 8,
    parameter int ADDR_W   = 16,
    parameter int BULK_MAX = 5120,
    parameter int CFG_MAX  = 27,
    localparam int N_BLK   = N_COL * N_ROW,
    localparam int COL_W   = $clog2(N_COL),
    localparam int ROW_W   = $clog2(N_ROW),
    localparam int CNT_W   = $clog2(BULK_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic              dat_valid,
    input  logic [7:0]        dat_byte,
    output logic              wr_en,
    output logic              wr_cfg,
    output logic [N_BLK-1:0]  wr_mask,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              err,
    output logic              ovf
);

    localparam logic [CNT_W-1:0] IDX_BULK_END = CNT_W'(BULK_MAX);
    localparam logic [CNT_W-1:0] IDX_CFG_END  = CNT_W'(CFG_MAX);

    op_e               cur_op;
    op_e               new_op;
    logic [CNT_W-1:0]  idx;
    logic              beat_go;
    logic [N_BLK-1:0]  mask;
    logic              sel_any;
    logic [ADDR_W-1:0] addr;
    logic              addr_ok;
    logic              bulk_ok;
    logic              cfg_ok;
    logic              bump;
    logic              new_ok;

    blkinit_cmd_track #(.BULK_MAX(BULK_MAX), .CNT_W(CNT_W)) trk_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .dat_valid(dat_valid), .cur_op(cur_op), .idx(idx), .beat_go(beat_go)
    );

    blkinit_sel #(.N_COL(N_COL), .N_ROW(N_ROW), .CNT_W(CNT_W)) sel_i (
        .clk(clk), .rst(rst), .beat_go(beat_go), .op(cur_op), .idx(idx),
        .col_bits(dat_byte[COL_W-1:0]), .row_bits(dat_byte[ROW_W-1:0]),
        .pat_bits(dat_byte[N_COL-1:0]), .mask(mask), .sel_any(sel_any)
    );

    blkinit_addr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) adr_i (
        .clk(clk), .rst(rst), .beat_go(beat_go), .op(cur_op), .idx(idx),
        .byte_in(dat_byte), .bump(bump), .addr(addr), .addr_ok(addr_ok)
    );

    assign new_op = op_e'(cmd_op);
    assign new_ok = sel_any && (addr_ok || !op_needs_addr(new_op));
    assign bump   = beat_go && bulk_ok && idx != IDX_BULK_END;

    always_ff @(posedge clk) begin
        if (rst) begin
            bulk_ok <= 1'b0;
            cfg_ok  <= 1'b0;
            wr_en   <= 1'b0;
            wr_cfg  <= WK_RAM;
            wr_mask <= '0;
            wr_addr <= '0;
            wr_data <= '0;
            err     <= 1'b0;
            ovf     <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (cmd_valid) begin
                bulk_ok <= (new_op == OP_BULK) && new_ok;
                cfg_ok  <= (new_op == OP_CFG) && new_ok;
                if (op_writes(new_op) && !new_ok)
                    err <= 1'b1;
            end else if (beat_go) begin
                if (bulk_ok) begin
                    if (idx != IDX_BULK_END) begin
                        wr_en   <= 1'b1;
                        wr_cfg  <= WK_RAM;
                        wr_mask <= mask;
                        wr_addr <= addr;
                        wr_data <= dat_byte;
                    end else begin
                        ovf <= 1'b1;
                    end
                end else if (cfg_ok && idx < IDX_CFG_END) begin
                    wr_en   <= 1'b1;
                    wr_cfg  <= WK_CFG;
                    wr_mask <= mask;
                    wr_addr <= ADDR_W'(idx);
                    wr_data <= dat_byte;
                end
            end
        end
    end

    // R5
    wr_target_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> wr_mask != '0);

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_cfg && $past(wr_en && !wr_cfg)) |->
            wr_addr == ADDR_W'($past(wr_addr) + 1'b1));

    // R9
    cfg_range_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_cfg) |-> wr_addr < ADDR_W'(CFG_MAX));

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf) |-> !wr_en);

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

endmodule

// File: tb/blkinit_loader_tb_top.sv
`timescale 1ns/1ps
module blkinit_loader_tb_top;

    localparam int BULK = 5120;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic        dat_valid = 1'b0;
    logic [7:0]  dat_byte = 8'd0;
    logic        wr_en, wr_cfg, err, ovf;
    logic [31:0] wr_mask;
    logic [15:0] wr_addr;
    logic [7:0]  wr_data;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    blkinit_loader dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .dat_valid(dat_valid), .dat_byte(dat_byte), .wr_en(wr_en),
        .wr_cfg(wr_cfg), .wr_mask(wr_mask), .wr_addr(wr_addr),
        .wr_data(wr_data), .err(err), .ovf(ovf)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cmd_valid = 1'b0; dat_valid = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic send_cmd(logic [2:0] op);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; dat_valid = 1'b0;
        @(posedge clk);
        #1 cmd_valid = 1'b0;
    endtask

    task automatic send_beat(logic [7:0] b);
        @(negedge clk);
        dat_valid = 1'b1; dat_byte = b;
        @(posedge clk);
        #1 dat_valid = 1'b0;
    endtask

    task automatic expect_wr(string tag, logic cfg, logic [31:0] m,
                             logic [15:0] a, logic [7:0] d);
        check({tag, " wr_en"}, wr_en, 1);
        check({tag, " wr_cfg"}, wr_cfg, cfg);
        check({tag, " wr_mask"}, wr_mask, m);
        check({tag, " wr_addr"}, wr_addr, a);
        check({tag, " wr_data"}, wr_data, d);
    endtask

    task automatic expect_none(string tag);
        check({tag, " no write"}, wr_en, 0);
    endtask

    task automatic set_addr(logic [15:0] a);
        send_cmd(3'd2);
        send_beat(a[7:0]);
        send_beat(a[15:8]);
    endtask

    function automatic logic [31:0] col_mask(logic [3:0] v);
        logic [31:0] m = '0;
        for (int c = 0; c < 4; c++)
            if (v[c])
                for (int r = 0; r < 8; r++) m[r*4 + c] = 1'b1;
        return m;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] m;
        do_reset();
        // R1 reset state and beat before any command
        check("R1 wr_en", wr_en, 0);
        check("R1 err", err, 0);
        check("R1 ovf", ovf, 0);
        send_beat(8'hAA);
        expect_none("R1 stray beat");

        // R2 sweep of all coordinates, high bits garbage
        for (int c = 0; c < 4; c++) begin
            for (int r = 0; r < 8; r++) begin
                send_cmd(3'd0);
                send_beat(8'(c + 4*((r*3) & 7)));
                expect_none("R2 select byte0");
                send_beat(8'(r + 8*((c*5 + r) & 31)));
                send_cmd(3'd4);
                send_beat(8'(c*8 + r));
                expect_wr("R2 coord", 1'b1, 32'(1) << (r*4 + c), 16'd0, 8'(c*8 + r));
            end
        end

        // R11 truncated select keeps previous selection
        send_cmd(3'd0); send_beat(8'd1); send_beat(8'd2);
        send_cmd(3'd0); send_beat(8'd3);
        send_cmd(3'd4); send_beat(8'h5A);
        expect_wr("R11 select kept", 1'b1, 32'(1) << 9, 16'd0, 8'h5A);

        // R3 pattern sweep with junk in bits 7:4
        for (int v = 1; v < 16; v++) begin
            send_cmd(3'd1);
            send_beat(8'(v | (((v*7) & 15) << 4)));
            send_cmd(3'd4);
            send_beat(8'(v));
            expect_wr("R3 pattern", 1'b1, col_mask(4'(v)), 16'd0, 8'(v));
        end
        send_cmd(3'd1); send_beat(8'h01);
        m = col_mask(4'h1);

        // R9 config length limit
        send_cmd(3'd4);
        for (int k = 0; k < 30; k++) begin
            send_beat(8'(k*3 + 1));
            if (k < 27) expect_wr("R9 cfg byte", 1'b1, m, 16'(k), 8'(k*3 + 1));
            else        expect_none("R9 cfg beyond limit");
        end
        check("R9 err clear", err, 0);
        check("R9 ovf clear", ovf, 0);

        // R4 R5 bulk stream
        set_addr(16'h1234);
        send_cmd(3'd3);
        for (int k = 0; k < 40; k++) begin
            send_beat(8'(k*11 + 5));
            expect_wr("R5 bulk", 1'b0, m, 16'(16'h1234 + k), 8'(k*11 + 5));
        end
        // R6 continue without new address
        send_cmd(3'd3);
        for (int k = 0; k < 3; k++) begin
            send_beat(8'(k + 100));
            expect_wr("R6 continue", 1'b0, m, 16'(16'h1234 + 40 + k), 8'(k + 100));
        end
        // R6 wrap
        set_addr(16'hFFFE);
        send_cmd(3'd3);
        for (int k = 0; k < 4; k++) begin
            send_beat(8'(k + 7));
            expect_wr("R6 wrap", 1'b0, m, 16'(16'hFFFE + k), 8'(k + 7));
        end
        // R11 truncated address keeps previous address
        send_cmd(3'd2); send_beat(8'h00);
        send_cmd(3'd3); send_beat(8'h41);
        expect_wr("R11 addr kept", 1'b0, m, 16'h0002, 8'h41);

        // R10 command and beat together
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd3; dat_valid = 1'b1; dat_byte = 8'h77;
        @(posedge clk);
        #1 cmd_valid = 1'b0; dat_valid = 1'b0;
        expect_none("R10 beat with command");
        send_beat(8'h78);
        expect_wr("R10 next beat", 1'b0, m, 16'h0003, 8'h78);
        // R10 unknown opcodes
        for (int op = 5; op < 8; op++) begin
            send_cmd(3'(op));
            send_beat(8'h3C);
            expect_none("R10 unknown op");
        end
        check("R10 err clear", err, 0);

        // R8 overflow
        set_addr(16'h0100);
        send_cmd(3'd3);
        for (int k = 0; k < BULK + 2; k++) begin
            send_beat(8'(k ^ (k >> 8)));
            if (k < BULK) begin
                expect_wr("R8 bulk body", 1'b0, m, 16'(16'h0100 + k), 8'(k ^ (k >> 8)));
                if (k == BULK - 1) check("R8 ovf before limit", ovf, 0);
            end else begin
                expect_none("R8 beyond limit");
                check("R8 ovf set", ovf, 1);
            end
        end
        check("R8 err clear", err, 0);

        // R7 bulk with no selection
        do_reset();
        set_addr(16'h0010);
        send_cmd(3'd3);
        check("R7 no select err", err, 1);
        send_beat(8'h11);
        expect_none("R7 no select write");
        send_cmd(3'd0);
        check("R7 err sticky", err, 1);

        // R7 bulk with no address
        do_reset();
        send_cmd(3'd0); send_beat(8'd2); send_beat(8'd5);
        send_cmd(3'd3);
        check("R7 no addr err", err, 1);
        send_beat(8'h22);
        expect_none("R7 no addr write");

        // R3 R9 zero pattern clears selection, config rejected
        do_reset();
        send_cmd(3'd1); send_beat(8'h0F);
        send_cmd(3'd1); send_beat(8'hF0);
        send_cmd(3'd4);
        check("R9 cfg no select err", err, 1);
        send_beat(8'h33);
        expect_none("R3 cleared selection");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule